// File: doc/BRIEF.md
# Serial Interface Status Flag Unit

This block keeps the eight event flags of a serial port that runs in one of two formats: a two-wire addressed bus or a plain clock-synchronous shift link. The shift engine beside it sends single-cycle event strobes: bus start and stop detection, the ninth clock, last bit shifted out or in, data moved between the holding, shift and receive registers, the first frame after a start, the acknowledge sample and an SDA compare at each rising SCL. The CPU side sends strobes for a status read, a status write, a transmit-data write and a receive-data read.

Each flag has set conditions that depend on the format. A single bit reports arbitration loss in bus format and overrun in synchronous format. Software clears a flag by writing 0 to it, but only after it has read that flag as 1 since the flag was last set. The flags, together with a per-flag enable mask, also form one interrupt request.

Top module: `sif_status_flags`

Status bit positions: [0] transmit empty, [1] transmit end, [2] receive full, [3] no-acknowledge, [4] stop seen, [5] arbitration lost / overrun, [6] own address matched, [7] general call.

## Requirements
- R1: After reset all eight status bits and `irq` are 0.
- R2: Bit 0 sets on any of `ev_tx_load`, `ev_trs_set`, `ev_start_gen` or `ev_slv_rx_to_tx`. `cpu_tx_wr` clears bits 0 and 1. Every flag update shows on `status` in the cycle after its strobe.
- R3: Bit 1 sets in bus format (`mode_bus`=1) on `ev_ninth_clk` only if bit 0 is already 1. In synchronous format it sets on `ev_tx_last_bit`.
- R4: Bit 2 sets on `ev_rx_xfer`. `cpu_rx_rd` clears it.
- R5: In bus format with `master`=1, bit 5 sets when `xmit`=1, `scl_rise`=1 and `sda_drv` differs from `sda_pin`. It also sets when `ev_start_det`=1 while `sda_pin`=1. It never sets from these when `master`=0.
- R6: In synchronous format, bit 5 sets on `ev_rx_last_bit` only while bit 2 is 1.
- R7: In bus format with `master`=0, `addr_vld` sets bit 6 when `xmit`=0 and `addr_frame[7:1]` equals `own_addr`. It sets bit 7 when `addr_frame` is 8'h00.
- R8: Bit 3 sets in bus format when `xmit`=1, `ev_ack_sample`=1, `ack_bit`=1 and `ack_chk_en`=1. With `ack_chk_en`=0 it stays 0.
- R9: Bit 4 sets on `ev_stop_det` in bus format only if an `ev_ninth_clk` has been seen since the last start or stop.
- R10: A status write clears bit i when `cpu_wdata[i]`=0 and bit i was read as 1 by `cpu_sts_rd` since it was last set. Without that read the bit keeps its value. Writing 1 has no effect.
- R11: A set event in the same cycle as a valid clear leaves the flag at 1.
- R12: `irq` is 1 exactly when some status bit and its `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_bus | input | 1 | 1 = two-wire bus format, 0 = synchronous format |
| master | input | 1 | Master mode |
| xmit | input | 1 | Transmit mode |
| ack_chk_en | input | 1 | Acknowledge checking enabled |
| own_addr | input | 7 | Programmed slave address |
| ev_tx_load | input | 1 | Holding data moved to shift register, holding now empty |
| ev_trs_set | input | 1 | Software switched to transmit mode |
| ev_start_gen | input | 1 | Start or repeated start generated |
| ev_slv_rx_to_tx | input | 1 | Slave receive changed to slave transmit |
| ev_ninth_clk | input | 1 | Ninth SCL clock of a frame |
| ev_tx_last_bit | input | 1 | Synchronous: last transmit bit shifted out |
| ev_rx_xfer | input | 1 | Received data moved to receive register |
| ev_rx_last_bit | input | 1 | Synchronous: last bit of a new item received |
| ev_ack_sample | input | 1 | Acknowledge bit sampled |
| ack_bit | input | 1 | Sampled acknowledge level (1 = none) |
| scl_rise | input | 1 | Rising SCL edge |
| sda_drv | input | 1 | SDA value being driven |
| sda_pin | input | 1 | SDA pin level |
| ev_start_det | input | 1 | Start condition detected |
| ev_stop_det | input | 1 | Stop condition detected |
| addr_vld | input | 1 | First frame after start is complete |
| addr_frame | input | 8 | That frame, address in [7:1] |
| cpu_sts_rd | input | 1 | Status register read |
| cpu_sts_wr | input | 1 | Status register write |
| cpu_wdata | input | 8 | Status write data |
| cpu_tx_wr | input | 1 | Transmit data register write |
| cpu_rx_rd | input | 1 | Receive data register read |
| irq_en | input | 8 | Per-flag interrupt enable |
| status | output | 8 | Flag bits |
| irq | output | 1 | Combined interrupt request |

## Verification
A hardware set and a software write-0 clear can fall on the same flag in the same cycle. The sweep covers every flag and every combination of three conditions: a prior read as 1 or none, a written value of 0 or 1, and a set strobe present or absent in the write cycle. The expected bit is 1 when a set is present and otherwise 0 only if a read came first and the written value was 0. A transmit-data write that lands together with a transmit-empty source is checked separately.

// File: rtl/sif_status_flags.sv
module sif_status_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_bus,
  input  logic       master,
  input  logic       xmit,
  input  logic       ack_chk_en,
  input  logic [6:0] own_addr,
  input  logic       ev_tx_load,
  input  logic       ev_trs_set,
  input  logic       ev_start_gen,
  input  logic       ev_slv_rx_to_tx,
  input  logic       ev_ninth_clk,
  input  logic       ev_tx_last_bit,
  input  logic       ev_rx_xfer,
  input  logic       ev_rx_last_bit,
  input  logic       ev_ack_sample,
  input  logic       ack_bit,
  input  logic       scl_rise,
  input  logic       sda_drv,
  input  logic       sda_pin,
  input  logic       ev_start_det,
  input  logic       ev_stop_det,
  input  logic       addr_vld,
  input  logic [7:0] addr_frame,
  input  logic       cpu_sts_rd,
  input  logic       cpu_sts_wr,
  input  logic [7:0] cpu_wdata,
  input  logic       cpu_tx_wr,
  input  logic       cpu_rx_rd,
  input  logic [7:0] irq_en,
  output logic [7:0] status,
  output logic       irq
);

  localparam int TDRE = 0, TEND = 1, RXF = 2, NACK = 3, STP = 4, ALO = 5, AMT = 6, GCL = 7;

  logic [7:0] flag_q, armed_q, set_ev, hw_clr, sw_clr, clr_all;
  logic       frame_seen_q;

  wire slave_rx = mode_bus & ~master & ~xmit;

  assign set_ev[TDRE] = ev_tx_load | ev_trs_set | ev_start_gen | ev_slv_rx_to_tx;
  assign set_ev[TEND] = mode_bus ? (ev_ninth_clk & flag_q[TDRE]) : ev_tx_last_bit;
  assign set_ev[RXF]  = ev_rx_xfer;
  assign set_ev[NACK] = mode_bus & xmit & ack_chk_en & ev_ack_sample & ack_bit;
  assign set_ev[STP]  = mode_bus & ev_stop_det & frame_seen_q;
  assign set_ev[ALO]  = mode_bus
                        ? (master & ((xmit & scl_rise & (sda_drv ^ sda_pin)) | (ev_start_det & sda_pin)))
                        : (ev_rx_last_bit & flag_q[RXF]);
  assign set_ev[AMT]  = slave_rx & addr_vld & (addr_frame[7:1] == own_addr);
  assign set_ev[GCL]  = mode_bus & ~master & addr_vld & (addr_frame == 8'h00);

  assign hw_clr  = {5'b0, cpu_rx_rd, cpu_tx_wr, cpu_tx_wr};
  assign sw_clr  = {8{cpu_sts_wr}} & armed_q & ~cpu_wdata;
  assign clr_all = hw_clr | sw_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q       <= '0;
      armed_q      <= '0;
      frame_seen_q <= 1'b0;
    end else begin
      flag_q  <= set_ev | (flag_q & ~clr_all);
      armed_q <= ~set_ev & ~clr_all & (armed_q | ({8{cpu_sts_rd}} & flag_q));
      if (ev_start_det || ev_stop_det)
        frame_seen_q <= 1'b0;
      else if (mode_bus && ev_ninth_clk)
        frame_seen_q <= 1'b1;
    end
  end

  assign status = flag_q;
  assign irq    = |(flag_q & irq_en);

  p_rx_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_xfer |=> status[RXF]);

  p_tend_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[TEND]) |-> $past(mode_bus ? (ev_ninth_clk && status[TDRE]) : ev_tx_last_bit));

  p_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_bus && ev_rx_last_bit && status[RXF]) |=> status[ALO]);

  p_nack_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[NACK]) |-> $past(ack_chk_en && mode_bus));

  p_stop_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[STP]) |-> $past(cpu_sts_wr && !cpu_wdata[STP]));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_trs_set && cpu_tx_wr) |=> status[TDRE]);

  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h00) |-> !irq);

endmodule

// File: tb/sif_status_flags_tb_top.sv
module sif_status_flags_tb_top;
  logic clk = 0, rst_n = 0;
  logic mode_bus, master, xmit, ack_chk_en;
  logic [6:0] own_addr;
  logic ev_tx_load, ev_trs_set, ev_start_gen, ev_slv_rx_to_tx, ev_ninth_clk, ev_tx_last_bit;
  logic ev_rx_xfer, ev_rx_last_bit, ev_ack_sample, ack_bit, scl_rise, sda_drv, sda_pin;
  logic ev_start_det, ev_stop_det, addr_vld;
  logic [7:0] addr_frame, cpu_wdata, irq_en, status;
  logic cpu_sts_rd, cpu_sts_wr, cpu_tx_wr, cpu_rx_rd, irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sif_status_flags dut_i (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic quiet();
    {ev_tx_load, ev_trs_set, ev_start_gen, ev_slv_rx_to_tx, ev_ninth_clk, ev_tx_last_bit} = '0;
    {ev_rx_xfer, ev_rx_last_bit, ev_ack_sample, scl_rise, ev_start_det, ev_stop_det, addr_vld} = '0;
    {cpu_sts_rd, cpu_sts_wr, cpu_tx_wr, cpu_rx_rd} = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    quiet();
  endtask

  task automatic clr_all();
    cpu_sts_rd = 1; tick();
    cpu_sts_wr = 1; cpu_wdata = 8'h00; tick();
  endtask

  task automatic mode(input logic b, input logic m, input logic x);
    mode_bus = b; master = m; xmit = x;
  endtask

  task automatic prep(input int i);
    if (i == 4) begin mode(1, 0, 0); ev_ninth_clk = 1; tick(); end
  endtask

  task automatic drive_set(input int i);
    case (i)
      0: ev_trs_set = 1;
      1: begin mode(0, 1, 1); ev_tx_last_bit = 1; end
      2: ev_rx_xfer = 1;
      3: begin mode(1, 1, 1); ack_chk_en = 1; ack_bit = 1; ev_ack_sample = 1; end
      4: begin mode(1, 0, 0); ev_stop_det = 1; end
      5: begin mode(1, 1, 1); scl_rise = 1; sda_drv = 1; sda_pin = 0; end
      6: begin mode(1, 0, 0); addr_vld = 1; addr_frame = {own_addr, 1'b0}; end
      default: begin mode(1, 0, 0); addr_vld = 1; addr_frame = 8'h00; end
    endcase
  endtask

  initial begin
    quiet();
    mode(1, 1, 1); ack_chk_en = 0; ack_bit = 0; sda_drv = 0; sda_pin = 0;
    own_addr = 7'h2A; addr_frame = 8'hFF; cpu_wdata = 8'hFF; irq_en = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 status", status, 8'h00); chk("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1; tick();

    ev_tx_load = 1;      tick(); chk("R2 load", status, 8'h01); clr_all();
    ev_start_gen = 1;    tick(); chk("R2 start", status, 8'h01); clr_all();
    ev_slv_rx_to_tx = 1; tick(); chk("R2 s2t", status, 8'h01); clr_all();
    mode(1, 1, 1); ev_ninth_clk = 1; tick(); chk("R3 no empty", status, 8'h00);
    ev_trs_set = 1; tick(); ev_ninth_clk = 1; tick(); chk("R3 bus tend", status, 8'h03);
    cpu_tx_wr = 1; tick(); chk("R2 tx_wr clears", status, 8'h00);
    ev_trs_set = 1; cpu_tx_wr = 1; tick(); chk("R11 tx_wr vs set", status, 8'h01); clr_all();
    ev_rx_xfer = 1; tick(); cpu_rx_rd = 1; tick(); chk("R4 rx_rd", status, 8'h00);
    mode(1, 1, 1); scl_rise = 1; sda_drv = 1; sda_pin = 1; tick(); chk("R5 match", status, 8'h00);
    mode(1, 0, 1); scl_rise = 1; sda_pin = 0; tick(); chk("R5 slave", status, 8'h00);
    mode(1, 1, 0); ev_start_det = 1; sda_pin = 1; tick(); chk("R5 start high", status, 8'h20); clr_all();
    mode(0, 0, 0); ev_rx_last_bit = 1; tick(); chk("R6 no ovr", status, 8'h00);
    ev_rx_xfer = 1; tick(); ev_rx_last_bit = 1; tick(); chk("R6 ovr", status, 8'h24); clr_all();
    mode(1, 0, 0); addr_vld = 1; addr_frame = 8'h2B; tick(); chk("R7 wrong addr", status, 8'h00);
    mode(1, 1, 0); addr_vld = 1; addr_frame = {own_addr, 1'b0}; tick(); chk("R7 master", status, 8'h00);
    mode(1, 1, 1); ack_chk_en = 0; ack_bit = 1; ev_ack_sample = 1; tick(); chk("R8 disabled", status, 8'h00);
    mode(1, 0, 0); ev_start_det = 1; tick(); ev_stop_det = 1; tick(); chk("R9 no frame", status, 8'h00);

    for (int i = 0; i < 8; i++)
      for (int c = 0; c < 8; c++) begin
        logic rd, wb, sc, exp;
        rd = c[0]; wb = c[1]; sc = c[2];
        clr_all(); prep(i); drive_set(i); tick();
        if (rd) begin cpu_sts_rd = 1; tick(); end
        prep(i);
        cpu_sts_wr = 1; cpu_wdata = ~(8'h01 << i) | ({7'b0, wb} << i);
        if (sc) drive_set(i);
        tick();
        exp = sc | ~(rd & ~wb);
        chk(sc ? "R11 sweep" : "R10 sweep", {7'b0, status[i]}, {7'b0, exp});
        irq_en = 8'h01 << i;
        @(posedge clk); #1;
        chk("R12 irq", {7'b0, irq}, {7'b0, exp});
        irq_en = 8'h00;
      end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hang exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule